// File: doc/BRIEF.md
# Programmable High/Low-Time Clock Divider

This block derives a slower clock from a fast input clock. Two counts set the shape of each output period: how many input cycles the output spends high, and how many it then spends low. The pattern repeats, so the output period is the sum of the two counts measured in input cycles.

A half-cycle extension control lets odd divide ratios reach a 50% duty cycle. With the extension set, the high-to-low transition is moved from a rising edge of the input clock to the following falling edge. The high phase then gains half an input cycle, the low phase loses the same half cycle, and the period does not change. A bypass control turns off the counting and passes the input clock straight through, which gives a divide by one.

New settings are presented on the configuration inputs and captured by a one-cycle load strobe. A captured set is held until the next high phase begins and is applied only then, so a change never cuts a phase short. Reset holds the output low. Each count is a 6-bit field, and the value 0 stands for 64.

Top module: `hlcd_clkdiv`

## Requirements
- R1: With the extension clear, the output stays high for exactly `cfg_high` input-clock cycles per period. Its rise and its fall both follow rising input edges.
- R2: With the extension clear, the output then stays low for exactly `cfg_low` input-clock cycles, so the period is `cfg_high + cfg_low` input cycles.
- R3: With `cfg_half_ext` = 1, the fall occurs on the falling input edge that ends the high count. The high phase lasts `cfg_high` + 0.5 cycles and the low phase lasts `cfg_low` - 0.5 cycles, and the period is unchanged. For example, high = 1 and low = 2 give 1.5 cycles each.
- R4: With `cfg_bypass` = 1 in effect, `clk_out` equals `clk_in` (divide by one). The count fields and the extension have no effect.
- R5: A count field of 0 is taken as 64 input cycles.
- R6: Settings on the configuration inputs are captured only on a rising input edge where `cfg_load` = 1. Changes without the strobe leave the output waveform unchanged.
- R7: A captured setting takes effect at the start of the next high phase. The phase in progress, and the low phase after it, finish with the previous values. When the strobe is seen on the very edge that starts a high phase, the new values wait for the following high phase.
- R8: While `rst` is high, `clk_out` is 0. The first high phase begins on the first rising input edge after `rst` falls.
- R9: Reset restores the settings to high = `DEF_HIGH` (2), low = `DEF_LOW` (2), extension clear and bypass clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst | input | 1 | Asynchronous reset, active high |
| cfg_load | input | 1 | Capture strobe for the configuration inputs |
| cfg_high | input | CNT_W | High-phase length in input cycles (0 = 64) |
| cfg_low | input | CNT_W | Low-phase length in input cycles (0 = 64) |
| cfg_half_ext | input | 1 | Move the fall to the falling input edge |
| cfg_bypass | input | 1 | Pass the input clock through unchanged |
| clk_out | output | 1 | Divided clock |

## Verification
The bench samples the output once in every half input cycle and compares each sample with a model. The model builds each period as a list of half-cycle levels from the captured counts. The sweep covers divides 2 to 8 with and without the extension, the bypass mode entered and left, and both counts at the 0-means-64 boundary. A design that moved its fall to the wrong edge, or that lost or doubled the half cycle, would stretch or shorten a phase by one sample. One that applied a load at once would cut a phase short. Loads are also issued at irregular moments and inputs are changed without a strobe, and a reset is applied in mid-run: a runt pulse, an ignored strobe that still took effect, or a late first high phase each show up as a sample that differs from the model.

// File: rtl/hlcd_pkg.sv
package hlcd_pkg;

  // Phase length in input cycles for a count field; an all-zero field means 2**width.
  function automatic int unsigned phase_len(input int unsigned field, input int unsigned width);
    if (field == 0) return 32'd1 << width;
    return field;
  endfunction

  // Half-cycles spent high in one period, given the extension flag.
  function automatic int unsigned high_halves(input int unsigned hi_cycles, input bit ext);
    return 2 * hi_cycles + (ext ? 1 : 0);
  endfunction

endpackage

// File: rtl/hlcd_cfg_regs.sv
module hlcd_cfg_regs #(
  parameter int CNT_W    = 6,
  parameter int DEF_HIGH = 2,
  parameter int DEF_LOW  = 2
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic             cfg_half_ext,
  input  logic             cfg_bypass,
  input  logic             apply_now,
  output logic [CNT_W-1:0] pend_high,
  output logic [CNT_W-1:0] act_high,
  output logic [CNT_W-1:0] act_low,
  output logic             act_ext,
  output logic             act_bypass
);

  logic [CNT_W-1:0] pend_low;
  logic             pend_ext;
  logic             pend_bypass;

  // Staging set: written by the strobe only.
  always_ff @(posedge clk_in or posedge rst) begin
    if (rst) begin
      pend_high   <= CNT_W'(DEF_HIGH);
      pend_low    <= CNT_W'(DEF_LOW);
      pend_ext    <= 1'b0;
      pend_bypass <= 1'b0;
    end else if (cfg_load) begin
      pend_high   <= cfg_high;
      pend_low    <= cfg_low;
      pend_ext    <= cfg_half_ext;
      pend_bypass <= cfg_bypass;
    end
  end

  // Active set: copied from staging only when a high phase starts.
  always_ff @(posedge clk_in or posedge rst) begin
    if (rst) begin
      act_high   <= CNT_W'(DEF_HIGH);
      act_low    <= CNT_W'(DEF_LOW);
      act_ext    <= 1'b0;
      act_bypass <= 1'b0;
    end else if (apply_now) begin
      act_high   <= pend_high;
      act_low    <= pend_low;
      act_ext    <= pend_ext;
      act_bypass <= pend_bypass;
    end
  end

endmodule

// File: rtl/hlcd_phase_ctr.sv
module hlcd_phase_ctr
  import hlcd_pkg::*;
#(
  parameter int CNT_W = 6,
  localparam int RUN_W = CNT_W + 1
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic [CNT_W-1:0] next_high,
  input  logic [CNT_W-1:0] act_low,
  input  logic             act_bypass,
  output logic             hi_q,
  output logic [RUN_W-1:0] remain,
  output logic             idle,
  output logic             start_high,
  output logic             end_high,
  output logic             low_done
);

  assign idle       = (remain == '0);
  assign low_done   = !hi_q && (remain == RUN_W'(1));
  // Bypass restarts a one-cycle "period" on every edge, so counting is effectively off.
  assign start_high = idle || act_bypass || low_done;
  assign end_high   = hi_q && (remain == RUN_W'(1)) && !start_high;

  always_ff @(posedge clk_in or posedge rst) begin
    if (rst) begin
      hi_q   <= 1'b0;
      remain <= '0;
    end else if (start_high) begin
      hi_q   <= 1'b1;
      remain <= RUN_W'(phase_len(32'(next_high), CNT_W));
    end else if (end_high) begin
      hi_q   <= 1'b0;
      remain <= RUN_W'(phase_len(32'(act_low), CNT_W));
    end else begin
      remain <= remain - RUN_W'(1);
    end
  end

endmodule

// File: rtl/hlcd_edge_mux.sv
module hlcd_edge_mux (
  input  logic clk_in,
  input  logic rst,
  input  logic hi_q,
  input  logic act_ext,
  input  logic act_bypass,
  output logic neg_q,
  output logic clk_out
);

  // Copy of the high-phase flag, retimed half a cycle later.
  always_ff @(negedge clk_in or posedge rst) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= hi_q;
  end

  // OR of two overlapping high windows: rise from hi_q, late fall from neg_q.
  assign clk_out = act_bypass ? clk_in : (hi_q | (act_ext & neg_q));

endmodule

// File: rtl/hlcd_clkdiv.sv
module hlcd_clkdiv #(
  parameter int CNT_W    = 6,
  parameter int DEF_HIGH = 2,
  parameter int DEF_LOW  = 2
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic             cfg_half_ext,
  input  logic             cfg_bypass,
  output logic             clk_out
);

  localparam int RUN_W = CNT_W + 1;

  logic [CNT_W-1:0] pend_high;
  logic [CNT_W-1:0] act_high;
  logic [CNT_W-1:0] act_low;
  logic             act_ext;
  logic             act_bypass;
  logic             hi_q;
  logic             neg_q;
  logic [RUN_W-1:0] remain;
  logic             idle;
  logic             start_high;
  logic             end_high;
  logic             low_done;

  hlcd_cfg_regs #(
    .CNT_W(CNT_W), .DEF_HIGH(DEF_HIGH), .DEF_LOW(DEF_LOW)
  ) u_cfg (
    .clk_in(clk_in), .rst(rst), .cfg_load(cfg_load),
    .cfg_high(cfg_high), .cfg_low(cfg_low),
    .cfg_half_ext(cfg_half_ext), .cfg_bypass(cfg_bypass),
    .apply_now(start_high), .pend_high(pend_high),
    .act_high(act_high), .act_low(act_low),
    .act_ext(act_ext), .act_bypass(act_bypass)
  );

  hlcd_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_in(clk_in), .rst(rst), .next_high(pend_high),
    .act_low(act_low), .act_bypass(act_bypass),
    .hi_q(hi_q), .remain(remain), .idle(idle),
    .start_high(start_high), .end_high(end_high), .low_done(low_done)
  );

  hlcd_edge_mux u_mux (
    .clk_in(clk_in), .rst(rst), .hi_q(hi_q),
    .act_ext(act_ext), .act_bypass(act_bypass),
    .neg_q(neg_q), .clk_out(clk_out)
  );

endmodule

// File: rtl/hlcd_clkdiv_chk.sv
module hlcd_clkdiv_chk
  import hlcd_pkg::*;
#(
  parameter int CNT_W = 6,
  localparam int RUN_W = CNT_W + 1
) (
  input logic             clk_in,
  input logic             rst,
  input logic             clk_out,
  input logic             hi_q,
  input logic             neg_q,
  input logic [RUN_W-1:0] remain,
  input logic [CNT_W-1:0] act_high,
  input logic [CNT_W-1:0] act_low,
  input logic             act_ext,
  input logic             act_bypass,
  input logic             idle,
  input logic             start_high,
  input logic             end_high,
  input logic             low_done
);

  logic [RUN_W:0] run_len;

  always_ff @(posedge clk_in or posedge rst) begin
    if (rst)                        run_len <= '0;
    else if (start_high || end_high) run_len <= (RUN_W+1)'(1);
    else                            run_len <= run_len + (RUN_W+1)'(1);
  end

  always_ff @(posedge clk_in) begin
    if (rst) AST_RESET_LOW: assert (!clk_out); // R8
  end

  AST_HIGH_LEN: assert property (@(posedge clk_in) disable iff (rst)
    end_high |-> 32'(run_len) == phase_len(32'(act_high), CNT_W)); // R1

  AST_LOW_LEN: assert property (@(posedge clk_in) disable iff (rst)
    (low_done && !act_bypass) |-> 32'(run_len) == phase_len(32'(act_low), CNT_W)); // R2

  AST_CFG_HOLD: assert property (@(posedge clk_in) disable iff (rst)
    !start_high |=> $stable({act_high, act_low, act_ext, act_bypass})); // R7

  AST_FIRST_HIGH: assert property (@(posedge clk_in) disable iff (rst)
    idle |=> hi_q); // R8

  AST_HALF_TRACK: assert property (@(posedge clk_in) disable iff (rst)
    neg_q == hi_q); // R3

  AST_REMAIN_NZ: assert property (@(posedge clk_in) disable iff (rst)
    !idle |=> remain != '0); // R5

endmodule

bind hlcd_clkdiv hlcd_clkdiv_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_in(clk_in), .rst(rst), .clk_out(clk_out), .hi_q(hi_q), .neg_q(neg_q),
  .remain(remain), .act_high(act_high), .act_low(act_low), .act_ext(act_ext),
  .act_bypass(act_bypass), .idle(idle), .start_high(start_high),
  .end_high(end_high), .low_done(low_done)
);

// File: tb/hlcd_clkdiv_bench.sv
`timescale 1ns/10ps
module hlcd_clkdiv_bench;

  localparam int W = 6;

  logic         clk_in = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_load = 1'b0;
  logic [W-1:0] cfg_high = '0;
  logic [W-1:0] cfg_low = '0;
  logic         cfg_half_ext = 1'b0;
  logic         cfg_bypass = 1'b0;
  logic         clk_out;

  int    vecs = 0;
  int    errs = 0;
  string tag = "R8 reset";

  always #2.5 clk_in = ~clk_in;  // 200 MHz

  hlcd_clkdiv #(.CNT_W(W)) u_hlcd_clkdiv (
    .clk_in(clk_in), .rst(rst), .cfg_load(cfg_load),
    .cfg_high(cfg_high), .cfg_low(cfg_low),
    .cfg_half_ext(cfg_half_ext), .cfg_bypass(cfg_bypass),
    .clk_out(clk_out)
  );

  // Model: each period becomes a list of half-cycle levels.
  bit q[$];
  int m_h = 2, m_l = 2;
  bit m_e = 0, m_b = 0;

  task automatic add_period(int h, int l, bit e, bit b);
    int hc, lc;
    if (b) begin q.push_back(1'b1); q.push_back(1'b0); return; end
    hc = (h == 0) ? 64 : h;   // R5
    lc = (l == 0) ? 64 : l;
    for (int i = 0; i < 2*hc + (e ? 1 : 0); i++) q.push_back(1'b1);
    for (int i = 0; i < 2*lc - (e ? 1 : 0); i++) q.push_back(1'b0);
  endtask

  task automatic compare_one();
    bit exp;
    exp = (q.size() == 0) ? 1'b0 : q.pop_front();
    vecs++;
    if (clk_out !== exp) begin
      errs++;
      $display("FAIL %s at %0t: clk_out=%b expected %b", tag, $time, clk_out, exp);
    end
  endtask

  always @(posedge clk_in) begin
    if (rst) begin
      q.delete();
      m_h = 2; m_l = 2; m_e = 0; m_b = 0;  // R9 defaults
    end else begin
      if (q.size() == 0) add_period(m_h, m_l, m_e, m_b);  // R7: old staged set applies
      if (cfg_load) begin                                  // R6: strobe only
        m_h = int'(cfg_high); m_l = int'(cfg_low);
        m_e = cfg_half_ext;   m_b = cfg_bypass;
      end
    end
    #1.25 compare_one();
  end

  always @(negedge clk_in) begin
    #1.25 compare_one();
  end

  task automatic load_cfg(int h, int l, bit e, bit b, string t);
    @(negedge clk_in);
    cfg_high = W'(h); cfg_low = W'(l); cfg_half_ext = e; cfg_bypass = b;
    cfg_load = 1'b1;
    @(negedge clk_in);
    cfg_load = 1'b0;
    tag = t;
  endtask

  task automatic idle_for(int n);
    repeat (n) @(negedge clk_in);
  endtask

  initial begin
    #(5.0 * 150000);
    errs++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    // R8: output low under reset
    idle_for(5);
    rst = 1'b0;
    tag = "R8 R9 first period with defaults";
    idle_for(20);

    // R1 R2 R3: divides 2..8, with and without the extension
    for (int d = 2; d <= 8; d++) begin
      for (int e = 0; e < 2; e++) begin
        load_cfg(d/2, d - d/2, e[0], 1'b0,
                 $sformatf("R1 R2 R3 div%0d ext%0d", d, e));
        idle_for(40);
      end
    end

    // R4: bypass, then back to counting
    load_cfg(5, 3, 1'b1, 1'b1, "R4 bypass divide by one");
    idle_for(30);
    load_cfg(1, 2, 1'b1, 1'b0, "R4 R7 leave bypass div3");
    idle_for(30);

    // R5: zero fields mean 64
    load_cfg(0, 1, 1'b0, 1'b0, "R5 high field zero");
    idle_for(150);
    load_cfg(3, 0, 1'b1, 1'b0, "R5 low field zero");
    idle_for(150);

    // R6: inputs moved without a strobe
    load_cfg(2, 3, 1'b0, 1'b0, "R6 baseline");
    idle_for(20);
    @(negedge clk_in);
    cfg_high = 6'd7; cfg_low = 6'd1; cfg_half_ext = 1'b1; cfg_bypass = 1'b1;
    tag = "R6 no strobe ignored";
    idle_for(40);

    // R7: strobes at irregular moments, including mid-phase
    for (int k = 0; k < 12; k++) begin
      load_cfg(1 + (k % 4), 1 + ((k * 3) % 5), k[0], (k % 5) == 4, "R7 mid-phase loads");
      idle_for(k % 3);
    end
    idle_for(40);

    // R8 R9: reset in mid-run restores defaults
    @(negedge clk_in);
    rst = 1'b1;
    tag = "R8 reset mid-run";
    idle_for(4);
    rst = 1'b0;
    tag = "R8 R9 restart with defaults";
    idle_for(24);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule